// File: doc/BRIEF.md
# DRAM Controller Operating Mode Tracker

This block follows the operating mode of a DRAM controller and reports it as a 3-bit status code that software polls. It takes a soft reset release bit, an indication that the DRAM initialization sequence has finished, and requests to enter or leave the low-power states. It drives a ready flag that allows read and write traffic only while the controller is in normal operation. DRAM command timing and the initialization command sequence are outside this block; initialization completion arrives as an input.

Internally, being held in soft reset and waiting for initialization are two separate states, although both report the same code. Deep power-down can only be reached when the design is built with LPDDR2 support and the LPDDR2 strap is high. Leaving deep power-down forces the DRAM to be initialized again. Every transition is registered, so a request sampled at a clock edge shows on the outputs right after that edge.

Top module: `dram_mode_tracker`

## Requirements
- R1: After `rst`, and for as long as `soft_rstb` is 0, `mode_code` is 3'b000 and `rw_ready` is 0; `init_done` has no effect in this held state.
- R2: The first edge with `soft_rstb` at 1 moves the block into a wait-for-initialization state that still reports 3'b000. Any later edge with `init_done` at 1 moves it to normal mode.
- R3: In normal mode `mode_code` is 3'b001 and `rw_ready` is 1; in every other state `rw_ready` is 0.
- R4: In normal mode `pd_enter` moves the block to power-down (3'b010); in power-down `pd_exit` returns it to normal.
- R5: In normal mode `sref_en` at 1 moves the block to self-refresh (3'b011). It stays there while `sref_en` is 1 and returns to normal on the first edge where `sref_en` is 0.
- R6: In normal mode with `lpddr2_strap` at 1, `dpd_enter` moves the block to deep power-down (3'b100). In deep power-down `dpd_exit` moves it to the wait-for-initialization state (3'b000), from which `init_done` is needed again.
- R7: When `lpddr2_strap` is 0, or the parameter `LPDDR2_CAPABLE` is 0, `dpd_enter` is ignored and the mode is unchanged.
- R8: When several entry requests coincide in normal mode, self-refresh wins over deep power-down, and deep power-down wins over power-down.
- R9: Low-power states are entered only from normal mode. While the block is in one low-power state, requests for another low-power state are ignored. A request still active after the exit takes effect on the following edge.
- R10: `soft_rstb` at 0 returns the block to the held state (3'b000) on the next edge from any state, overriding all other requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rstb | input | 1 | Soft reset release: 1 releases, 0 holds |
| init_done | input | 1 | DRAM initialization sequence finished |
| pd_enter | input | 1 | Request power-down entry |
| pd_exit | input | 1 | Request power-down exit |
| sref_en | input | 1 | Self-refresh enable level |
| lpddr2_strap | input | 1 | LPDDR2 configuration strap |
| dpd_enter | input | 1 | Request deep power-down entry |
| dpd_exit | input | 1 | Request deep power-down exit |
| mode_code | output | 3 | Current operating mode code |
| rw_ready | output | 1 | Read/write requests accepted |

## Verification
The bench pulses `init_done` while soft reset is still held. A design that merged the two uninitialized states would then jump straight to normal mode. It raises `sref_en` during power-down and checks that self-refresh follows only after the power-down exit; a design that allowed lateral moves would skip normal mode. It asserts coinciding entry requests, with the strap both high and low, to expose a wrong priority or an ungated deep power-down. It also checks that leaving deep power-down lands in the wait-for-initialization state rather than in normal mode.

// File: rtl/dmt_pkg.sv
package dmt_pkg;

    localparam int MODE_W  = 3;
    localparam int STATE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        MODE_UNINIT = 3'b000,
        MODE_NORMAL = 3'b001,
        MODE_PDOWN  = 3'b010,
        MODE_SREF   = 3'b011,
        MODE_DPD    = 3'b100
    } mode_code_e;

    typedef enum logic [STATE_W-1:0] {
        ST_HOLD      = 3'd0,
        ST_WAIT_INIT = 3'd1,
        ST_NORMAL    = 3'd2,
        ST_PDOWN     = 3'd3,
        ST_SREF      = 3'd4,
        ST_DPD       = 3'd5
    } track_state_e;

    typedef struct packed {
        logic go_sref;
        logic go_dpd;
        logic go_pd;
    } entry_req_t;

    typedef struct packed {
        logic leave_pd;
        logic leave_sref;
        logic leave_dpd;
    } exit_req_t;

    function automatic mode_code_e code_of(input track_state_e s);
        mode_code_e c;
        case (s)
            ST_NORMAL: c = MODE_NORMAL;
            ST_PDOWN:  c = MODE_PDOWN;
            ST_SREF:   c = MODE_SREF;
            ST_DPD:    c = MODE_DPD;
            default:   c = MODE_UNINIT;
        endcase
        return c;
    endfunction

    function automatic logic is_low_power(input track_state_e s);
        return (s == ST_PDOWN) || (s == ST_SREF) || (s == ST_DPD);
    endfunction

endpackage

// File: rtl/dmt_req_filter.sv
module dmt_req_filter
    import dmt_pkg::*;
#(
    parameter bit LPDDR2_CAPABLE = 1'b1
) (
    input  logic       pd_enter,
    input  logic       pd_exit,
    input  logic       sref_en,
    input  logic       lpddr2_strap,
    input  logic       dpd_enter,
    input  logic       dpd_exit,
    output entry_req_t entry,
    output exit_req_t  leave
);

    logic dpd_allowed;

    generate
        if (LPDDR2_CAPABLE) begin : g_lpddr2
            assign dpd_allowed = dpd_enter & lpddr2_strap;
        end else begin : g_no_lpddr2
            logic unused_dpd;
            assign unused_dpd  = dpd_enter ^ lpddr2_strap;
            assign dpd_allowed = 1'b0;
        end
    endgenerate

    // Entry priority: self-refresh, then deep power-down, then power-down (R8)
    always_comb begin
        entry.go_sref = sref_en;
        entry.go_dpd  = dpd_allowed & ~sref_en;
        entry.go_pd   = pd_enter & ~sref_en & ~dpd_allowed;
    end

    always_comb begin
        leave.leave_pd   = pd_exit;
        leave.leave_sref = ~sref_en;
        leave.leave_dpd  = dpd_exit;
    end

endmodule

// File: rtl/dmt_state_fsm.sv
module dmt_state_fsm
    import dmt_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         soft_rstb,
    input  logic         init_done,
    input  entry_req_t   entry,
    input  exit_req_t    leave,
    output track_state_e state
);

    track_state_e state_nx;

    always_comb begin
        state_nx = state;
        if (!soft_rstb) begin
            state_nx = ST_HOLD;
        end else begin
            case (state)
                ST_HOLD:      state_nx = ST_WAIT_INIT;
                ST_WAIT_INIT: if (init_done) state_nx = ST_NORMAL;
                ST_NORMAL: begin
                    if (entry.go_sref)     state_nx = ST_SREF;
                    else if (entry.go_dpd) state_nx = ST_DPD;
                    else if (entry.go_pd)  state_nx = ST_PDOWN;
                end
                ST_PDOWN:     if (leave.leave_pd)   state_nx = ST_NORMAL;
                ST_SREF:      if (leave.leave_sref) state_nx = ST_NORMAL;
                ST_DPD:       if (leave.leave_dpd)  state_nx = ST_WAIT_INIT;
                default:      state_nx = ST_HOLD;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_HOLD;
        else     state <= state_nx;
    end

    assert_soft_reset_wins_R10: assert property (@(posedge clk) disable iff (rst)
        !soft_rstb |=> state == ST_HOLD);

    assert_init_ignored_in_hold_R1: assert property (@(posedge clk) disable iff (rst)
        state == ST_HOLD |=> state != ST_NORMAL);

    assert_lowpower_from_normal_R9: assert property (@(posedge clk) disable iff (rst)
        (is_low_power(state) && state != $past(state)) |-> $past(state) == ST_NORMAL);

    assert_dpd_exit_reinit_R6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DPD && soft_rstb && leave.leave_dpd) |=> state == ST_WAIT_INIT);

    assert_entry_onehot_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(entry));

endmodule

// File: rtl/dmt_status_out.sv
module dmt_status_out
    import dmt_pkg::*;
(
    input  track_state_e      state,
    output logic [MODE_W-1:0] mode_code,
    output logic              rw_ready
);

    always_comb begin
        mode_code = code_of(state);
        rw_ready  = (state == ST_NORMAL);
    end

endmodule

// File: rtl/dram_mode_tracker.sv
module dram_mode_tracker
    import dmt_pkg::*;
#(
    parameter bit LPDDR2_CAPABLE = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rstb,
    input  logic              init_done,
    input  logic              pd_enter,
    input  logic              pd_exit,
    input  logic              sref_en,
    input  logic              lpddr2_strap,
    input  logic              dpd_enter,
    input  logic              dpd_exit,
    output logic [MODE_W-1:0] mode_code,
    output logic              rw_ready
);

    entry_req_t   entry;
    exit_req_t    leave;
    track_state_e state;

    dmt_req_filter #(.LPDDR2_CAPABLE(LPDDR2_CAPABLE)) u_filter (
        .pd_enter    (pd_enter),
        .pd_exit     (pd_exit),
        .sref_en     (sref_en),
        .lpddr2_strap(lpddr2_strap),
        .dpd_enter   (dpd_enter),
        .dpd_exit    (dpd_exit),
        .entry       (entry),
        .leave       (leave)
    );

    dmt_state_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .soft_rstb(soft_rstb),
        .init_done(init_done),
        .entry    (entry),
        .leave    (leave),
        .state    (state)
    );

    dmt_status_out u_status (
        .state    (state),
        .mode_code(mode_code),
        .rw_ready (rw_ready)
    );

    assert_ready_only_normal_R3: assert property (@(posedge clk) disable iff (rst)
        rw_ready |-> mode_code == MODE_NORMAL);

    assert_dpd_needs_strap_R7: assert property (@(posedge clk) disable iff (rst)
        (mode_code == MODE_DPD && $past(mode_code) != MODE_DPD) |-> $past(lpddr2_strap));

    assert_sref_stays_R5: assert property (@(posedge clk) disable iff (rst)
        (mode_code == MODE_SREF && sref_en && soft_rstb) |=> mode_code == MODE_SREF);

endmodule

// File: tb/tb_dram_mode_tracker.sv
module tb_dram_mode_tracker;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst, soft_rstb, init_done, pd_enter, pd_exit, sref_en;
    logic       lpddr2_strap, dpd_enter, dpd_exit;
    logic [2:0] mode_code;
    logic       rw_ready;

    dram_mode_tracker dut (
        .clk(clk), .rst(rst), .soft_rstb(soft_rstb), .init_done(init_done),
        .pd_enter(pd_enter), .pd_exit(pd_exit), .sref_en(sref_en),
        .lpddr2_strap(lpddr2_strap), .dpd_enter(dpd_enter), .dpd_exit(dpd_exit),
        .mode_code(mode_code), .rw_ready(rw_ready)
    );

    int total = 0;
    int bad   = 0;
    int model = 0; // 0 held, 1 wait init, 2 normal, 3 pdown, 4 sref, 5 dpd

    function automatic int code_for(input int s);
        case (s)
            2: return 1;
            3: return 2;
            4: return 3;
            5: return 4;
            default: return 0;
        endcase
    endfunction

    function automatic string tag_for(input int s);
        case (s)
            0: return "R10";
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4: return "R5";
            default: return "R6";
        endcase
    endfunction

    function automatic int model_next(input int s);
        if (rst || !soft_rstb) return 0;
        case (s)
            0: return 1;
            1: return init_done ? 2 : 1;
            2: begin
                if (sref_en) return 4;
                if (dpd_enter && lpddr2_strap) return 5;
                if (pd_enter) return 3;
                return 2;
            end
            3: return pd_exit ? 2 : 3;
            4: return sref_en ? 4 : 2;
            default: return dpd_exit ? 1 : 5;
        endcase
    endfunction

    task automatic compare(input string tag);
        total++;
        if (int'(mode_code) != code_for(model)) begin
            bad++;
            $display("FAIL %s mode_code actual=%0d expected=%0d", tag, mode_code, code_for(model));
        end
        total++;
        if (rw_ready != (model == 2)) begin
            bad++;
            $display("FAIL %s rw_ready actual=%0d expected=%0d", tag, rw_ready, (model == 2));
        end
    endtask

    // Called at a negedge: drive, clock once, compare at the next negedge
    task automatic step(input string tag, input logic r, input logic srb, input logic idn,
                        input logic pde, input logic pdx, input logic sre, input logic strap,
                        input logic dpe, input logic dpx);
        rst = r; soft_rstb = srb; init_done = idn; pd_enter = pde; pd_exit = pdx;
        sref_en = sre; lpddr2_strap = strap; dpd_enter = dpe; dpd_exit = dpx;
        #1;
        model = model_next(model);
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired (all requirements) actual=hung expected=finished");
        finish_run();
    end

    initial begin
        rst = 1'b1; soft_rstb = 1'b0; init_done = 1'b0; pd_enter = 1'b0; pd_exit = 1'b0;
        sref_en = 1'b0; lpddr2_strap = 1'b0; dpd_enter = 1'b0; dpd_exit = 1'b0;
        @(negedge clk);
        //        tag    rst srb idn pde pdx sre stp dpe dpx
        step("R1",  1, 0, 0, 0, 0, 0, 0, 0, 0);
        step("R1",  1, 0, 0, 0, 0, 0, 0, 0, 0);
        // R1: init_done while soft reset held is ignored
        step("R1",  0, 0, 1, 0, 0, 0, 0, 0, 0);
        step("R1",  0, 0, 1, 0, 0, 0, 0, 0, 0);
        // R2: release with init_done already high: first edge only leaves hold
        step("R2",  0, 1, 1, 0, 0, 0, 0, 0, 0);
        step("R2",  0, 1, 0, 0, 0, 0, 0, 0, 0);
        step("R2",  0, 1, 0, 0, 0, 0, 0, 0, 0);
        step("R3",  0, 1, 1, 0, 0, 0, 0, 0, 0);
        step("R3",  0, 1, 0, 0, 0, 0, 0, 0, 0);
        // R4 power-down entry and stay
        step("R4",  0, 1, 0, 1, 0, 0, 0, 0, 0);
        step("R4",  0, 1, 0, 0, 0, 0, 0, 0, 0);
        // R9: self-refresh request inside power-down ignored
        step("R9",  0, 1, 0, 0, 0, 1, 1, 1, 0);
        step("R9",  0, 1, 0, 0, 1, 1, 0, 0, 0);
        step("R9",  0, 1, 0, 0, 0, 1, 0, 0, 0);
        // R5: stays in self-refresh, leaves when sref_en drops
        step("R5",  0, 1, 0, 1, 1, 1, 1, 1, 1);
        step("R5",  0, 1, 0, 0, 0, 0, 0, 0, 0);
        // R7: deep power-down request with strap low
        step("R7",  0, 1, 0, 0, 0, 0, 0, 1, 0);
        step("R7",  0, 1, 0, 0, 0, 0, 0, 1, 0);
        // R8: all entry requests together, strap high -> self-refresh
        step("R8",  0, 1, 0, 1, 0, 1, 1, 1, 0);
        step("R8",  0, 1, 0, 1, 0, 0, 1, 1, 0);
        // R8: deep power-down over power-down
        step("R8",  0, 1, 0, 1, 0, 0, 1, 1, 0);
        step("R6",  0, 1, 1, 0, 0, 0, 1, 0, 0);
        // R6: exit lands in wait-for-init, not normal
        step("R6",  0, 1, 1, 0, 0, 0, 1, 0, 1);
        step("R6",  0, 1, 0, 0, 0, 0, 1, 0, 0);
        step("R6",  0, 1, 1, 0, 0, 0, 1, 0, 0);
        // R8/R7: power-down chosen when strap low
        step("R8",  0, 1, 0, 1, 0, 0, 0, 1, 0);
        // R10: soft reset from power-down overrides exit
        step("R10", 0, 0, 1, 0, 1, 0, 0, 0, 0);
        step("R10", 0, 1, 1, 0, 0, 0, 0, 0, 0);
        step("R10", 0, 1, 1, 0, 0, 0, 0, 0, 0);
        step("R10", 0, 1, 0, 0, 0, 1, 0, 0, 0);
        step("R10", 0, 0, 0, 0, 0, 1, 0, 0, 0);
        // Mixed traffic against the reference model
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r;
            r = $urandom;
            step(tag_for(model), 1'b0, (r[4:0] != 5'd0), r[5] & r[6], r[7] & r[8],
                 r[9], r[10] | (sref_en & r[11]), r[12] | r[13], r[14] & r[15] & r[16],
                 r[17]);
        end
        finish_run();
    end

endmodule